// File: doc/BRIEF.md
# Dual-Master Bus Ownership Controller

This block decides which of two upstream bus masters owns a shared downstream two-wire bus. Each master reaches the block through an access strobe that carries a command: take ownership, give it up, load its configuration, or just touch its control register. The block drives one connect enable per upstream channel and never raises both at once. When ownership has to move to a channel, the block does not connect it straight away. It raises a switch request towards an external bus-recovery sequencer and keeps both channels disconnected until the sequencer acknowledges.

Each master has an active-low interrupt output, modelled as open-drain: 0 drives it low and 1 releases it. The output carries two sources. The first is a latched "you lost the bus" event, set when the other master takes over. The second is the downstream active-low interrupt, passed through only if that master has enabled forwarding. A build-time parameter chooses whether channel 0 is connected after reset or no channel is connected.

Top module: `bus_owner_sel`

## Requirements
- R1: `chan_en` never has both bits set.
- R2: When master m issues a take (`acc_cmd` field value 1) and does not already hold the bus, `chan_en` is 0 and `seq_req`=1 with `seq_tgt`=m from the next cycle on. This lasts until a cycle with `seq_ack`=1, after which `chan_en` has only bit m set.
- R3: With `BOOT_CH0`=1, reset leaves `chan_en`=01, so channel 0 owns the bus. With `BOOT_CH0`=0, reset leaves `chan_en`=00 and `seq_req`=0.
- R4: A take by one master while the other holds the bus, committed or pending, latches a lost-control event for the previous holder. That holder's `up_int_n` goes low in the next cycle.
- R5: If both masters issue a take in the same cycle, master 0 becomes the holder and master 1 gets the lost-control event.
- R6: Any access by a master clears that master's latched lost-control event from the next cycle. A new event raised in the same cycle takes precedence over the clear.
- R7: While `ds_int_n` is low, `up_int_n[m]` is low if master m has forwarding enabled. Forwarding enabled means configuration bit 0 is set by a config command, `acc_cmd` value 3.
- R8: While master m has configuration bit 1 (lost mask) set, no lost-control event is latched for m.
- R9: A give-up (`acc_cmd` value 2) from the holder disconnects both channels in the next cycle and issues no switch request. A give-up from a master that is not the holder has no effect.
- R10: `seq_ack` has no effect when no switch is pending. A take from the master that already holds the bus has no effect.
- R11: Asserting `rst_n` low at any time restores the power-up state: power-up ownership, forwarding off, masks clear and no latched events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_vld | input | 2 | Access strobe, bit m for master m |
| acc_cmd | input | 4 | Command per master, bits [2m+1:2m]: 0 touch, 1 take, 2 give up, 3 config |
| acc_cfg | input | 4 | Config per master, bits [2m+1:2m]: bit 0 forward enable, bit 1 lost mask |
| ds_int_n | input | 1 | Downstream interrupt, active low |
| seq_ack | input | 1 | Sequencer has finished the requested switch |
| seq_req | output | 1 | Switch request pending towards the sequencer |
| seq_tgt | output | 1 | Channel the pending switch connects |
| chan_en | output | 2 | Connect enable per upstream channel |
| up_int_n | output | 2 | Interrupt per master, active low, open-drain style |

## Verification
A reference model in the bench compares every output on every cycle. The stimulus starts with directed sequences and then moves to a long random mix of accesses, acknowledges and downstream interrupts.

The directed cases isolate one behaviour each:
- A single takeover with a delayed acknowledge shows that both channels stay disconnected during the switch.
- Simultaneous takes show the channel 0 priority.
- A masked takeover shows that the mask suppresses the lost-control event.
- Give-ups from the holder and from the non-holder show that only the holder can release the bus.
- A reset in the middle of a switch shows that all state returns to power-up.

The random phase adds combinations the directed cases skip, such as an acknowledge arriving in the same cycle as a fresh takeover. A second instance built without power-up ownership covers the other reset variant.

// File: rtl/bus_owner_pkg.sv
package bus_owner_pkg;
    localparam int NMST  = 2;
    localparam int CMD_W = 2;
    localparam int CFG_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_TOUCH = 2'd0,
        CMD_TAKE  = 2'd1,
        CMD_DROP  = 2'd2,
        CMD_CFG   = 2'd3
    } own_cmd_e;

    typedef struct packed {
        logic [NMST-1:0] en;
        logic            busy;
        logic            hold_vld;
        logic            hold_id;
    } own_state_t;

    typedef struct packed {
        logic fwd;
        logic mask;
        logic lost;
    } irq_state_t;
endpackage

// File: rtl/bus_owner_irq.sv
module bus_owner_irq
    import bus_owner_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_val,
    input  logic             lost_set,
    input  logic             ds_int_n,
    output logic             int_n
);
    irq_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (acc) s_d.lost = 1'b0;
        if (cfg_wr) begin
            s_d.fwd  = cfg_val[0];
            s_d.mask = cfg_val[1];
        end
        if (lost_set && !s_q.mask) s_d.lost = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign int_n = !(s_q.lost || (s_q.fwd && !ds_int_n));

    // R6
    lost_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !lost_set) |=> !s_q.lost);
    // R8
    lost_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mask && !s_q.lost) |=> !s_q.lost);
endmodule

// File: rtl/bus_owner_sel.sv
module bus_owner_sel
    import bus_owner_pkg::*;
#(
    parameter bit BOOT_CH0 = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NMST-1:0]       acc_vld,
    input  logic [NMST*CMD_W-1:0] acc_cmd,
    input  logic [NMST*CFG_W-1:0] acc_cfg,
    input  logic                  ds_int_n,
    input  logic                  seq_ack,
    output logic                  seq_req,
    output logic                  seq_tgt,
    output logic [NMST-1:0]       chan_en,
    output logic [NMST-1:0]       up_int_n
);
    localparam own_state_t BOOT_STATE = '{
        en:       BOOT_CH0 ? 2'b01 : 2'b00,
        busy:     1'b0,
        hold_vld: BOOT_CH0,
        hold_id:  1'b0
    };

    own_state_t      s_d, s_q;
    logic [NMST-1:0] take, drop, cfg_wr, lost_set;
    logic            win_vld, win_id;

    always_comb begin
        for (int m = 0; m < NMST; m++) begin
            own_cmd_e c;
            c         = own_cmd_e'(acc_cmd[m*CMD_W +: CMD_W]);
            take[m]   = acc_vld[m] && (c == CMD_TAKE);
            drop[m]   = acc_vld[m] && (c == CMD_DROP);
            cfg_wr[m] = acc_vld[m] && (c == CMD_CFG);
        end
        win_vld = |take;
        win_id  = !take[0];
    end

    always_comb begin
        s_d      = s_q;
        lost_set = '0;
        // commit a finished switch
        if (s_q.busy && seq_ack) begin
            s_d.busy = 1'b0;
            s_d.en   = s_q.hold_id ? 2'b10 : 2'b01;
        end
        // give-up only by the current holder
        for (int m = 0; m < NMST; m++) begin
            if (drop[m] && s_d.hold_vld && (s_d.hold_id == m[0])) begin
                s_d.hold_vld = 1'b0;
                s_d.busy     = 1'b0;
                s_d.en       = '0;
            end
        end
        // takeover, channel 0 wins a tie
        if (win_vld) begin
            if (&take) lost_set[1] = 1'b1;
            if (!(s_d.hold_vld && s_d.hold_id == win_id)) begin
                if (s_d.hold_vld) lost_set[s_d.hold_id] = 1'b1;
                s_d.hold_vld = 1'b1;
                s_d.hold_id  = win_id;
                s_d.busy     = 1'b1;
                s_d.en       = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= BOOT_STATE;
        else        s_q <= s_d;
    end

    assign seq_req = s_q.busy;
    assign seq_tgt = s_q.hold_id;
    assign chan_en = s_q.en;

    for (genvar g = 0; g < NMST; g++) begin : g_irq
        bus_owner_irq u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc      (acc_vld[g]),
            .cfg_wr   (cfg_wr[g]),
            .cfg_val  (acc_cfg[g*CFG_W +: CFG_W]),
            .lost_set (lost_set[g]),
            .ds_int_n (ds_int_n),
            .int_n    (up_int_n[g])
        );
    end

    // R1
    one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_en));
    // R2
    idle_during_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_req |-> (chan_en == '0));
    // R2
    commit_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_req && seq_ack && acc_vld == '0) |=> (chan_en != '0));
    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_req && seq_ack && acc_vld == '0) |=> $stable(chan_en));
endmodule

// File: tb/bus_owner_sel_bench.sv
module bus_owner_sel_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] acc_vld = '0;
    logic [3:0] acc_cmd = '0;
    logic [3:0] acc_cfg = '0;
    logic       ds_int_n = 1'b1;
    logic       seq_ack = 1'b0;
    logic       seq_req, seq_tgt;
    logic [1:0] chan_en, up_int_n;
    logic       b_req, b_tgt;
    logic [1:0] b_en, b_int;

    int cmp_n = 0;
    int bad_n = 0;

    always #5 clk = ~clk;

    bus_owner_sel u_bus_owner_sel (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_cmd(acc_cmd),
        .acc_cfg(acc_cfg), .ds_int_n(ds_int_n), .seq_ack(seq_ack),
        .seq_req(seq_req), .seq_tgt(seq_tgt), .chan_en(chan_en), .up_int_n(up_int_n)
    );

    bus_owner_sel #(.BOOT_CH0(1'b0)) u_bus_owner_sel_nb (
        .clk(clk), .rst_n(rst_n), .acc_vld(2'b00), .acc_cmd(4'h0),
        .acc_cfg(4'h0), .ds_int_n(1'b1), .seq_ack(1'b0),
        .seq_req(b_req), .seq_tgt(b_tgt), .chan_en(b_en), .up_int_n(b_int)
    );

    // reference model
    int m_hold;                 // -1: nobody
    bit m_busy;
    bit [1:0] m_en;
    bit m_lost[2], m_fwd[2], m_msk[2];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_hold = 0; m_busy = 0; m_en = 2'b01;
            for (int i = 0; i < 2; i++) begin m_lost[i] = 0; m_fwd[i] = 0; m_msk[i] = 0; end
        end else begin
            bit setl[2];
            bit old_msk[2];
            setl[0] = 0; setl[1] = 0;
            old_msk[0] = m_msk[0]; old_msk[1] = m_msk[1];
            if (m_busy && seq_ack) begin m_busy = 0; m_en = (m_hold == 1) ? 2'b10 : 2'b01; end
            for (int i = 0; i < 2; i++)
                if (acc_vld[i] && acc_cmd[2*i +: 2] == 2 && m_hold == i) begin
                    m_hold = -1; m_busy = 0; m_en = 0;
                end
            begin
                bit t0, t1;
                int w;
                t0 = acc_vld[0] && acc_cmd[1:0] == 1;
                t1 = acc_vld[1] && acc_cmd[3:2] == 1;
                if (t0 && t1) setl[1] = 1;
                w = t0 ? 0 : (t1 ? 1 : -1);
                if (w >= 0 && m_hold != w) begin
                    if (m_hold >= 0) setl[m_hold] = 1;
                    m_hold = w; m_busy = 1; m_en = 0;
                end
            end
            for (int i = 0; i < 2; i++) begin
                if (acc_vld[i]) m_lost[i] = 0;
                if (acc_vld[i] && acc_cmd[2*i +: 2] == 3) begin
                    m_fwd[i] = acc_cfg[2*i]; m_msk[i] = acc_cfg[2*i+1];
                end
                if (setl[i] && !old_msk[i]) m_lost[i] = 1;
            end
        end
    end

    task automatic check(input string tag, input string what, input int act, input int exp);
        cmp_n++;
        if (act != exp) begin
            bad_n++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            bit [1:0] ei;
            for (int i = 0; i < 2; i++)
                ei[i] = !(m_lost[i] || (m_fwd[i] && !ds_int_n));
            check("R1/R2/R5/R9/R10/R11", "chan_en", chan_en, m_en);
            check("R2", "seq_req", seq_req, m_busy);
            if (m_busy) check("R2/R5", "seq_tgt", seq_tgt, m_hold);
            check("R4/R6/R7/R8", "up_int_n", up_int_n, ei);
        end
    end

    // one cycle of stimulus: held from just after one edge to just after the next
    task automatic cyc(input bit [1:0] v, input bit [3:0] c, input bit [3:0] f,
                       input bit ack, input bit ds);
        acc_vld = v; acc_cmd = c; acc_cfg = f; seq_ack = ack; ds_int_n = ds;
        @(posedge clk); #1;
        acc_vld = '0; seq_ack = 1'b0; ds_int_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R3: power-up states of both builds
        check("R3", "boot ch0 en", chan_en, 2'b01);
        check("R3", "no-boot en", b_en, 2'b00);
        check("R3", "no-boot req", b_req, 0);
        @(posedge clk); #1;
        // R7: master 0 forwards, master 1 does not
        cyc(2'b11, 4'b11_11, 4'b00_01, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 0, 0);
        cyc(2'b00, 4'h0, 4'h0, 0, 1);
        // R2/R4: master 1 takes, ack delayed
        cyc(2'b10, 4'b01_00, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 1, 1);
        cyc(2'b00, 4'h0, 4'h0, 0, 1);
        // R6: master 0 touch clears its event
        cyc(2'b01, 4'b00_00, 4'h0, 0, 1);
        // R10: stray ack, take by holder
        cyc(2'b00, 4'h0, 4'h0, 1, 1);
        cyc(2'b10, 4'b01_00, 4'h0, 0, 1);
        // R8: master 1 masks, master 0 takes over
        cyc(2'b10, 4'b11_00, 4'b10_00, 0, 1);
        cyc(2'b01, 4'b00_01, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 1, 1);
        // R5: master 1 unmasks and takes, then both take
        cyc(2'b10, 4'b11_00, 4'b00_00, 0, 1);
        cyc(2'b10, 4'b01_00, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 1, 1);
        cyc(2'b11, 4'b01_01, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 1, 1);
        // R9: non-holder give-up ignored, holder give-up disconnects
        cyc(2'b10, 4'b10_00, 4'h0, 0, 1);
        cyc(2'b01, 4'b00_10, 4'h0, 0, 1);
        cyc(2'b00, 4'h0, 4'h0, 0, 1);
        // R11: reset in the middle of a pending switch
        cyc(2'b10, 4'b01_00, 4'h0, 0, 1);
        rst_n = 1'b0;
        @(posedge clk); #1;
        rst_n = 1'b1;
        cyc(2'b00, 4'h0, 4'h0, 0, 0);
        // random mix, all requirements against the model
        for (int k = 0; k < 3000; k++)
            cyc(2'($urandom), 4'($urandom), 4'($urandom),
                ($urandom % 3) == 0, ($urandom % 4) != 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
        $finish;
    end

    initial begin
        #1000000;
        bad_n++;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
        $finish;
    end
endmodule